// File: doc/BRIEF.md
# Phase-Shifted Dual Half-Bridge Gate Generator

This block drives the four switches of an isolated DC-DC stage built from two half-bridges, one on each side of a high-frequency transformer. Each side gets a complementary pair of gates running at a fixed 50% duty cycle at the switching frequency. The secondary pair is delayed or advanced against the primary pair by a commanded number of clock ticks, and the sign of that offset sets which way power flows. A regulator outside this block computes the shift magnitude and direction. This block turns them into gate waveforms that contain no glitches.

The switching carrier is a free-running tick counter over one switching period. Its first half is the "high" half of a carrier-versus-zero comparison and its second half is the "low" half. The secondary pair reads the same counter, offset forward or backward by the latched shift. The latched shift and direction update only on the last tick of a period. Each complementary pair passes through a dead-time stage that holds both of its gates low for a set number of ticks around every transition. Dropping the enable forces all four gates low in the same cycle. The next enable restarts the carrier from tick zero.

Top module: `sps_gate_gen`

## Requirements
- R1: While `en` stays high, `gp_hi` rises once every `PERIOD_TICKS` (= `CLK_HZ/FSW_HZ`) cycles and stays high for `PERIOD_TICKS/2 - DEAD_TICKS` cycles each time.
- R2: In each pair (`gp_hi`/`gp_lo` and `gs_hi`/`gs_lo`) the two gates are never high together, and a gate rises exactly `DEAD_TICKS` low cycles after its partner falls.
- R3: With `shift_req` = 0, `gs_hi` rises in the same cycle as `gp_hi`.
- R4: With `dir_v2g` = 0 (power into the battery side), `gs_hi` rises `shift_req` cycles after `gp_hi`, so the primary pair leads.
- R5: With `dir_v2g` = 1 (power toward the grid side), `gs_hi` rises `shift_req` cycles before `gp_hi`, so the primary pair lags: the rise comes `PERIOD_TICKS - shift_req` cycles after a `gp_hi` rise.
- R6: A `shift_req` of `PERIOD_TICKS/2` or more acts as `PERIOD_TICKS/2 - 1`.
- R7: `shift_req` and `dir_v2g` are sampled only on the last tick of a period, or while `en` is low. A change in the middle of a period leaves the current period unchanged.
- R8: While `rst` has been applied or `en` is low, all four gates are low, and `en` low clears them in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces all gates low |
| shift_req | input | SHIFT_W | Phase-shift magnitude in clock ticks |
| dir_v2g | input | 1 | 0: primary pair leads; 1: primary pair lags |
| gp_hi | output | 1 | Primary high-side gate |
| gp_lo | output | 1 | Primary low-side gate (complement of gp_hi) |
| gs_hi | output | 1 | Secondary high-side gate |
| gs_lo | output | 1 | Secondary low-side gate (complement of gs_hi) |

## Verification
The carrier position is a register. A gate therefore turns off one cycle after the position crosses a half-period boundary and turns on `DEAD_TICKS + 1` cycles after that crossing. Dropping `en` clears the gates in the same cycle. A new shift or direction shows up only in the period after the next last-tick edge, and the secondary rise it produces sits a whole phase offset away from the primary rise. On every rising edge a bench model advances its own carrier and gate history and queues the four gate values due for the next cycle. A monitor compares them at the falling edge, when the design has settled. Phase, period and width checks are taken from edge timestamps only after several full periods, so any pending load has completed by then.

// File: rtl/sps_pkg.sv
package sps_pkg;

    typedef int unsigned u32_t;

    // 0: primary pair leads (power into battery), 1: primary pair lags
    typedef enum logic {
        DIR_G2V = 1'b0,
        DIR_V2G = 1'b1
    } flow_dir_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;

    typedef struct packed {
        logic sec;
        logic prim;
    } raw_phase_t;

    localparam int NUM_PAIRS = 2;

    // clamp a shift request to just under half a period
    function automatic u32_t sat_shift(input u32_t req, input u32_t half);
        return (req >= half) ? (half - 1) : req;
    endfunction

    // carrier position seen by the secondary pair
    function automatic u32_t sec_pos(input u32_t pos, input u32_t sh,
                                     input flow_dir_e d, input u32_t period);
        u32_t s;
        if (d == DIR_V2G) s = pos + sh;
        else              s = pos + period - sh;
        if (s >= period)  s = s - period;
        return s;
    endfunction

endpackage

// File: rtl/sps_carrier.sv
module sps_carrier
    import sps_pkg::*;
#(
    parameter int unsigned PERIOD_TICKS = 200,
    parameter int unsigned SHIFT_W      = 16,
    parameter int unsigned CW           = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [SHIFT_W-1:0] shift_req,
    input  flow_dir_e          dir_req,
    output logic [CW-1:0]      pos,
    output logic [CW-1:0]      act_shift,
    output flow_dir_e          act_dir
);

    localparam u32_t HALF = PERIOD_TICKS / 2;
    localparam logic [CW-1:0] LAST = CW'(PERIOD_TICKS - 1);

    logic at_last;
    logic load_now;

    always_comb begin
        at_last  = (pos == LAST);
        load_now = !en || at_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos       <= LAST;
            act_shift <= '0;
            act_dir   <= DIR_G2V;
        end else begin
            if (load_now) begin
                act_shift <= CW'(sat_shift(u32_t'(shift_req), HALF));
                act_dir   <= dir_req;
            end
            if (!en)          pos <= LAST;
            else if (at_last) pos <= '0;
            else              pos <= pos + 1'b1;
        end
    end

endmodule

// File: rtl/sps_phase.sv
module sps_phase
    import sps_pkg::*;
#(
    parameter int unsigned PERIOD_TICKS = 200,
    parameter int unsigned CW           = 8
) (
    input  logic [CW-1:0] pos,
    input  logic [CW-1:0] act_shift,
    input  flow_dir_e     act_dir,
    output raw_phase_t    raw
);

    localparam u32_t HALF = PERIOD_TICKS / 2;

    u32_t spos;

    always_comb begin
        spos     = sec_pos(u32_t'(pos), u32_t'(act_shift), act_dir, PERIOD_TICKS);
        raw.prim = (u32_t'(pos) < HALF);
        raw.sec  = (spos < HALF);
    end

endmodule

// File: rtl/sps_deadband.sv
module sps_deadband
    import sps_pkg::*;
#(
    parameter int unsigned DEAD_TICKS = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       raw_in,
    output gate_pair_t gates
);

    localparam int unsigned TW = $clog2(DEAD_TICKS + 1);
    localparam logic [TW-1:0] TMAX = TW'(DEAD_TICKS);

    logic          prev;
    logic [TW-1:0] tmr;
    logic          settled;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            prev <= 1'b0;
            tmr  <= '0;
        end else begin
            prev <= raw_in;
            if (raw_in != prev)  tmr <= '0;
            else if (tmr != TMAX) tmr <= tmr + 1'b1;
        end
    end

    always_comb begin
        settled  = (tmr == TMAX);
        gates.hi = en && prev && settled;
        gates.lo = en && !prev && settled;
    end

endmodule

// File: rtl/sps_gate_gen.sv
module sps_gate_gen
    import sps_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 10_000_000,
    parameter int unsigned FSW_HZ     = 50_000,
    parameter int unsigned DEAD_TICKS = 3,
    parameter int unsigned SHIFT_W    = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [SHIFT_W-1:0] shift_req,
    input  logic               dir_v2g,
    output logic               gp_hi,
    output logic               gp_lo,
    output logic               gs_hi,
    output logic               gs_lo
);

    localparam int unsigned PERIOD_TICKS = CLK_HZ / FSW_HZ;
    localparam int unsigned CW = $clog2(PERIOD_TICKS);

    logic [CW-1:0]        pos;
    logic [CW-1:0]        act_shift;
    flow_dir_e            act_dir;
    raw_phase_t           raw;
    logic [NUM_PAIRS-1:0] raw_bits;
    gate_pair_t           pair [NUM_PAIRS];

    sps_carrier #(
        .PERIOD_TICKS(PERIOD_TICKS),
        .SHIFT_W     (SHIFT_W),
        .CW          (CW)
    ) u_carrier (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .shift_req(shift_req),
        .dir_req  (flow_dir_e'(dir_v2g)),
        .pos      (pos),
        .act_shift(act_shift),
        .act_dir  (act_dir)
    );

    sps_phase #(
        .PERIOD_TICKS(PERIOD_TICKS),
        .CW          (CW)
    ) u_phase (
        .pos      (pos),
        .act_shift(act_shift),
        .act_dir  (act_dir),
        .raw      (raw)
    );

    assign raw_bits = {raw.sec, raw.prim};

    generate
        for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
            sps_deadband #(
                .DEAD_TICKS(DEAD_TICKS)
            ) u_db (
                .clk   (clk),
                .rst   (rst),
                .en    (en),
                .raw_in(raw_bits[i]),
                .gates (pair[i])
            );
        end
    endgenerate

    assign gp_hi = pair[0].hi;
    assign gp_lo = pair[0].lo;
    assign gs_hi = pair[1].hi;
    assign gs_lo = pair[1].lo;

endmodule

// File: rtl/sps_gate_gen_chk.sv
module sps_gate_gen_chk #(
    parameter int PERIOD_TICKS = 200,
    parameter int DEAD_TICKS   = 3
) (
    input logic clk,
    input logic rst,
    input logic en,
    input logic gp_hi,
    input logic gp_lo,
    input logic gs_hi,
    input logic gs_lo
);

    localparam int HALF = PERIOD_TICKS / 2;

    int   low_run_p;
    int   low_run_s;
    int   hi_run;
    int   since_rise;
    logic had_rise;
    logic hi_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run_p  <= 0;
            low_run_s  <= 0;
            hi_run     <= 0;
            since_rise <= 0;
            had_rise   <= 1'b0;
            hi_d       <= 1'b0;
        end else begin
            low_run_p <= (gp_hi || gp_lo) ? 0 : ((low_run_p < PERIOD_TICKS) ? low_run_p + 1 : low_run_p);
            low_run_s <= (gs_hi || gs_lo) ? 0 : ((low_run_s < PERIOD_TICKS) ? low_run_s + 1 : low_run_s);
            hi_run    <= gp_hi ? hi_run + 1 : 0;
            hi_d      <= gp_hi;
            if (gp_hi && !hi_d) since_rise <= 0;
            else if (since_rise < 2 * PERIOD_TICKS) since_rise <= since_rise + 1;
            if (!en) had_rise <= 1'b0;
            else if (gp_hi && !hi_d) had_rise <= 1'b1;
        end
    end

    // R2
    pair_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(gp_hi && gp_lo) && !(gs_hi && gs_lo));

    // R2
    prim_dead_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(gp_hi) || $rose(gp_lo)) |-> (low_run_p >= DEAD_TICKS));

    // R2
    sec_dead_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(gs_hi) || $rose(gs_lo)) |-> (low_run_s >= DEAD_TICKS));

    // R8
    off_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> !(gp_hi || gp_lo || gs_hi || gs_lo));

    // R1
    period_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(gp_hi) && had_rise) |-> (since_rise == PERIOD_TICKS - 1));

    // R1
    width_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(gp_hi) && en) |-> (hi_run == HALF - DEAD_TICKS));

endmodule

bind sps_gate_gen sps_gate_gen_chk #(
    .PERIOD_TICKS(PERIOD_TICKS),
    .DEAD_TICKS  (DEAD_TICKS)
) u_chk (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .gp_hi(gp_hi),
    .gp_lo(gp_lo),
    .gs_hi(gs_hi),
    .gs_lo(gs_lo)
);

// File: tb/sps_gate_gen_tb.sv
module sps_gate_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 10_000_000;
    localparam int FSW_HZ     = 50_000;
    localparam int DEAD       = 3;
    localparam int SW         = 16;
    localparam int P          = CLK_HZ / FSW_HZ;
    localparam int HALF       = P / 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          en;
    logic [SW-1:0] shift_req;
    logic          dir_v2g;
    logic          gp_hi, gp_lo, gs_hi, gs_lo;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sps_gate_gen #(
        .CLK_HZ    (CLK_HZ),
        .FSW_HZ    (FSW_HZ),
        .DEAD_TICKS(DEAD),
        .SHIFT_W   (SW)
    ) u_dut (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .shift_req(shift_req),
        .dir_v2g  (dir_v2g),
        .gp_hi    (gp_hi),
        .gp_lo    (gp_lo),
        .gs_hi    (gs_hi),
        .gs_lo    (gs_lo)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R8";

    typedef struct {
        logic [3:0] exp;
        string      req;
    } item_t;
    item_t sb_q[$];

    // ---------------- reference model (pushes expected items) ----------------
    int   m_pos = P - 1;
    int   m_shift = 0;
    logic m_dir = 1'b0;
    logic hp [DEAD+1];
    logic hs [DEAD+1];
    int   vc = 0;

    always @(posedge clk) begin
        logic  rp, rs, p1, p0, s1, s0;
        int    sp;
        item_t it;
        rp = (m_pos < HALF);
        sp = m_dir ? (m_pos + m_shift) % P : (m_pos + P - m_shift) % P;
        rs = (sp < HALF);
        if (rst || !en) begin
            hp[0] = 1'b0; hs[0] = 1'b0; vc = 1;
        end else begin
            for (int i = DEAD; i > 0; i--) begin
                hp[i] = hp[i-1]; hs[i] = hs[i-1];
            end
            hp[0] = rp; hs[0] = rs;
            if (vc < DEAD + 1) vc++;
        end
        if (rst) begin
            m_pos = P - 1; m_shift = 0; m_dir = 1'b0;
        end else begin
            if (!en || m_pos == P - 1) begin
                m_shift = (int'(shift_req) >= HALF) ? HALF - 1 : int'(shift_req);
                m_dir   = dir_v2g;
            end
            if (!en)               m_pos = P - 1;
            else if (m_pos == P-1) m_pos = 0;
            else                   m_pos++;
        end
        p1 = 1'b1; p0 = 1'b1; s1 = 1'b1; s0 = 1'b1;
        for (int i = 0; i <= DEAD; i++) begin
            if (!hp[i]) p1 = 1'b0;
            if (hp[i])  p0 = 1'b0;
            if (!hs[i]) s1 = 1'b0;
            if (hs[i])  s0 = 1'b0;
        end
        it.exp[3] = en && !rst && (vc == DEAD + 1) && p1;
        it.exp[2] = en && !rst && (vc == DEAD + 1) && p0;
        it.exp[1] = en && !rst && (vc == DEAD + 1) && s1;
        it.exp[0] = en && !rst && (vc == DEAD + 1) && s0;
        it.req = cur_req;
        sb_q.push_back(it);
    end

    // ---------------- monitor ----------------
    int   cyc = 0;
    int   last_rise1 = 0, prev_rise1 = 0, last_fall1 = 0;
    int   last_rise2 = 0, last_rise3 = 0;
    int   n_rise1 = 0, n_rise3 = 0;
    logic d1 = 1'b0, d2 = 1'b0, d3 = 1'b0;

    always @(negedge clk) begin
        item_t it;
        cyc++;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            n_tests++;
            if ({gp_hi, gp_lo, gs_hi, gs_lo} !== it.exp) begin
                n_fail++;
                $display("FAIL %s gates at cycle %0d: got %b expected %b",
                         it.req, cyc, {gp_hi, gp_lo, gs_hi, gs_lo}, it.exp);
            end
        end
        if (gp_hi === 1'b1 && !d1) begin
            prev_rise1 = last_rise1; last_rise1 = cyc; n_rise1++;
        end
        if (gp_hi === 1'b0 && d1) last_fall1 = cyc;
        if (gp_lo === 1'b1 && !d2) last_rise2 = cyc;
        if (gs_hi === 1'b1 && !d3) begin
            last_rise3 = cyc; n_rise3++;
        end
        d1 = (gp_hi === 1'b1);
        d2 = (gp_lo === 1'b1);
        d3 = (gs_hi === 1'b1);
    end

    // ---------------- driver / directed checks ----------------
    task automatic expect_eq(input int got, input int exp, input string tag);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic apply(input int sh, input logic d, input string tag);
        @(negedge clk); #1;
        shift_req = SW'(sh);
        dir_v2g   = d;
        cur_req   = tag;
    endtask

    task automatic check_phase(input int exp_delta, input string tag);
        repeat (3 * P) @(negedge clk);
        #2;
        expect_eq(((last_rise3 - last_rise1) % P + P) % P, exp_delta, tag);
    endtask

    task automatic wait_rise1();
        int c;
        c = n_rise1;
        while (n_rise1 == c) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic wait_rise3();
        int c;
        c = n_rise3;
        while (n_rise3 == c) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        finish_run();
    end

    initial begin
        rst = 1'b1; en = 1'b0; shift_req = '0; dir_v2g = 1'b0;
        repeat (5) @(negedge clk);
        #1;
        // R8: reset holds all gates low
        expect_eq(int'({gp_hi, gp_lo, gs_hi, gs_lo}), 0, "R8 reset");
        rst = 1'b0;
        repeat (6) @(negedge clk);
        #1;
        expect_eq(int'({gp_hi, gp_lo, gs_hi, gs_lo}), 0, "R8 disabled");

        // R4: primary leads
        shift_req = SW'(30); cur_req = "R4"; en = 1'b1;
        check_phase(30, "R4 lead 30");
        // R1: period and high width
        expect_eq(last_rise1 - prev_rise1, P, "R1 period");
        expect_eq(((last_fall1 - last_rise1) % P + P) % P, HALF - DEAD, "R1 width");
        // R2: dead time from high-side fall to low-side rise
        expect_eq(((last_rise2 - last_fall1) % P + P) % P, DEAD, "R2 dead time");

        apply(30, 1'b1, "R5");
        check_phase(P - 30, "R5 lag 30");
        apply(0, 1'b0, "R3");
        check_phase(0, "R3 zero shift");
        apply(77, 1'b1, "R5");
        check_phase(P - 77, "R5 lag 77");
        apply(55, 1'b0, "R4");
        check_phase(55, "R4 lead 55");

        // R6: saturation
        apply(250, 1'b0, "R6");
        check_phase(HALF - 1, "R6 sat lead");
        apply(16'hFFFF, 1'b1, "R6");
        check_phase(P - (HALF - 1), "R6 sat lag");
        apply(HALF, 1'b0, "R6");
        check_phase(HALF - 1, "R6 at half");

        // R7: mid-period change waits for the period boundary
        apply(30, 1'b0, "R7");
        repeat (3 * P) @(negedge clk);
        wait_rise1();
        shift_req = SW'(60);
        wait_rise3();
        expect_eq(last_rise3 - last_rise1, 30, "R7 old shift kept");
        wait_rise1();
        wait_rise3();
        expect_eq(last_rise3 - last_rise1, 60, "R7 new shift applied");
        wait_rise1();
        dir_v2g = 1'b1;
        wait_rise3();
        expect_eq(last_rise3 - last_rise1, 60, "R7 old direction kept");
        check_phase(P - 60, "R7 new direction applied");

        // R8: disable mid-period clears gates in the same cycle
        cur_req = "R8";
        wait_rise1();
        repeat (5) @(negedge clk);
        #1;
        en = 1'b0;
        #1;
        expect_eq(int'({gp_hi, gp_lo, gs_hi, gs_lo}), 0, "R8 disable");
        repeat (20) @(negedge clk);
        #1;
        expect_eq(int'({gp_hi, gp_lo, gs_hi, gs_lo}), 0, "R8 stay low");
        shift_req = SW'(40); dir_v2g = 1'b0; cur_req = "R4"; en = 1'b1;
        check_phase(40, "R4 after restart");

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule